// File: doc/BRIEF.md
# Adaptive Minimal/Detour Global Port Chooser

This block makes the per-packet global routing decision for one router in a group-based network where every group has a direct global link to every other group. For each request it forms two candidates: the minimal one, which is the global port wired straight to the destination group, and a detour one, which is the global port toward an intermediate group drawn pseudo-randomly. It compares the queue occupancies of the two candidate ports, with a bias in favour of the minimal path, and returns the chosen port, a flag that marks the packet as detoured, and the intermediate group the packet must visit.

A detour costs one extra global hop: the packet goes from this group to the intermediate group and from there to its destination. When such a packet reaches the intermediate group it is presented again with its detour flag set, and it then goes straight to the destination with no new evaluation. Packets whose destination is the local group receive an intra-group code instead of a global port. The bias threshold is an input; it is normally tied to a value equal to one or two packets of queue depth. The pseudo-random source is built in and steps once per accepted request, so that the sequence of choices can be reproduced.

Top module: `ugal_path_chooser`

## Requirements
- R1: A request sampled with `reqValid` high on a rising clock edge produces `rspValid` high for exactly one cycle after the next rising edge, with the decision held on `rspPort`, `rspNonMin` and `rspMidGrp`; after reset `rspValid` is low and all three decision outputs are zero.
- R2: Global ports are numbered per router: from local group h, group g is reached through port g when g < h and through port g-1 when g > h, giving ports 0 to G-2; port code G-1 means intra-group delivery. The occupancy of port p sits at bits [p*OCC_W +: OCC_W] of `occFlat`.
- R3: When the destination group equals the local group, the response is port code G-1 with `rspNonMin` = 0 and `rspMidGrp` = 0, whatever the occupancies.
- R4: A request with `reqNonMin` = 1 and a destination other than the local group is sent to the minimal port of the destination group with `rspNonMin` = 0 and `rspMidGrp` = 0, even when that port's queue is full.
- R5: Otherwise the minimal port is chosen exactly when its occupancy is strictly less than the threshold plus the detour port's occupancy; equality chooses the detour.
- R6: The threshold-plus-occupancy sum saturates at 2^OCC_W-1 instead of wrapping (with OCC_W = 8: threshold 200, detour occupancy 100, minimal occupancy 250 chooses minimal).
- R7: The intermediate group is the current 16-bit random value modulo G; if that equals the local or the destination group it is advanced by one modulo G, and advanced once more if it still collides, so it never equals either.
- R8: The random value is a 16-bit right-shifting Galois register with feedback mask 0xB400, starting at 0xACE1 after reset; the draw for a request uses the value present when the request is accepted, and the register steps once per accepted request of any kind and never on idle cycles.
- R9: When the detour is chosen, `rspNonMin` = 1, `rspMidGrp` is the intermediate group and `rspPort` is the port toward it; when the minimal port is chosen, `rspNonMin` = 0 and `rspMidGrp` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqHereGrp | input | clog2(G) | Group of this router |
| reqDstGrp | input | clog2(G) | Destination group of the packet |
| reqNonMin | input | 1 | Packet already detoured, now on its second global hop |
| occFlat | input | (G-1)*OCC_W | Occupancy of each global port queue, port p at [p*OCC_W +: OCC_W] |
| biasThr | input | OCC_W | Bias threshold favouring the minimal path |
| rspValid | output | 1 | Decision valid |
| rspPort | output | clog2(G) | Chosen global port, or G-1 for intra-group |
| rspNonMin | output | 1 | Detour chosen for this packet |
| rspMidGrp | output | clog2(G) | Intermediate group when detoured, else 0 |

## Verification
The bench aims at the exact tie between the minimal occupancy and the biased detour occupancy, where a design using less-or-equal would keep the minimal port, and at a sum that overflows the occupancy width, where a wrapping adder would drop to a small number and wrongly detour. It sends second-hop packets whose minimal queue is full, which a design that re-evaluates would divert again, and local-group packets, which a design lacking the special case would give a global port. A long run of draws with local and destination groups placed next to each other makes the random value hit both groups, so a single collision step or a missing one shows up as an intermediate group equal to an endpoint or a mismatch with the modelled sequence, and idle gaps between requests expose a register that steps every cycle.

// File: rtl/ugal_pkg.sv
package ugal_pkg;

  localparam int RAND_W = 16;
  localparam logic [RAND_W-1:0] RAND_MASK = 16'hB400;
  localparam logic [RAND_W-1:0] RAND_SEED = 16'hACE1;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic localDst;   // destination is this group
    logic forceMin;   // second global hop, no adaptive choice
  } ctrlStrb_t;

  function automatic logic [RAND_W-1:0] randStep(input logic [RAND_W-1:0] cur);
    logic [RAND_W-1:0] nxt;
    nxt = cur >> 1;
    if (cur[0]) nxt = nxt ^ RAND_MASK;
    return nxt;
  endfunction

endpackage

// File: rtl/ugal_ctrl.sv
module ugal_ctrl
  import ugal_pkg::*;
#(
  parameter int NUM_GROUPS = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic [$clog2(NUM_GROUPS)-1:0]   reqHereGrp,
  input  logic [$clog2(NUM_GROUPS)-1:0]   reqDstGrp,
  input  logic                            reqNonMin,
  output ctrlStrb_t                       strb,
  output logic [RAND_W-1:0]               randVal,
  output logic                            rspValid
);

  logic [RAND_W-1:0] randReg;

  always_comb begin
    strb.accept   = reqValid;
    strb.localDst = (reqHereGrp == reqDstGrp);
    strb.forceMin = reqNonMin;
  end

  assign randVal = randReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      randReg  <= RAND_SEED;
      rspValid <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) randReg <= randStep(randReg);
    end
  end

endmodule

// File: rtl/ugal_datapath.sv
module ugal_datapath
  import ugal_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int OCC_W      = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctrlStrb_t                             strb,
  input  logic [RAND_W-1:0]                     randVal,
  input  logic [$clog2(NUM_GROUPS)-1:0]         hereGrp,
  input  logic [$clog2(NUM_GROUPS)-1:0]         dstGrp,
  input  logic [(NUM_GROUPS-1)*OCC_W-1:0]       occFlat,
  input  logic [OCC_W-1:0]                      biasThr,
  output logic [$clog2(NUM_GROUPS)-1:0]         rspPort,
  output logic                                  rspNonMin,
  output logic [$clog2(NUM_GROUPS)-1:0]         rspMidGrp
);

  localparam int GW    = $clog2(NUM_GROUPS);
  localparam int NPORT = NUM_GROUPS - 1;
  localparam logic [GW-1:0] LOCAL_CODE = GW'(NUM_GROUPS - 1);
  localparam logic [GW-1:0] LAST_GRP   = GW'(NUM_GROUPS - 1);

  logic [OCC_W-1:0] occArr [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_unpack
    assign occArr[p] = occFlat[p*OCC_W +: OCC_W];
  end

  function automatic logic [GW-1:0] portToward(input logic [GW-1:0] h,
                                               input logic [GW-1:0] g);
    return (g < h) ? g : g - 1'b1;
  endfunction

  function automatic logic [GW-1:0] wrapInc(input logic [GW-1:0] x);
    return (x == LAST_GRP) ? '0 : x + 1'b1;
  endfunction

  logic [GW-1:0]    midRaw, midOnce, midGrp;
  logic [GW-1:0]    minPort, nonPort, minIdx, nonIdx;
  logic [OCC_W-1:0] occMin, occNon, biasedNon;
  logic [OCC_W:0]   wideSum;
  logic             takeMin;

  always_comb begin
    // intermediate group draw with collision skipping
    midRaw  = GW'(randVal % RAND_W'(NUM_GROUPS));
    midOnce = (midRaw == hereGrp || midRaw == dstGrp) ? wrapInc(midRaw) : midRaw;
    midGrp  = (midOnce == hereGrp || midOnce == dstGrp) ? wrapInc(midOnce) : midOnce;

    minPort = portToward(hereGrp, dstGrp);
    nonPort = portToward(hereGrp, midGrp);
    minIdx  = (minPort > GW'(NPORT - 1)) ? '0 : minPort;
    nonIdx  = (nonPort > GW'(NPORT - 1)) ? '0 : nonPort;
    occMin  = occArr[minIdx];
    occNon  = occArr[nonIdx];

    // saturating biased comparison
    wideSum   = {1'b0, biasThr} + {1'b0, occNon};
    biasedNon = wideSum[OCC_W] ? '1 : wideSum[OCC_W-1:0];
    takeMin   = occMin < biasedNon;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPort   <= '0;
      rspNonMin <= 1'b0;
      rspMidGrp <= '0;
    end else if (strb.accept) begin
      if (strb.localDst) begin
        rspPort   <= LOCAL_CODE;
        rspNonMin <= 1'b0;
        rspMidGrp <= '0;
      end else if (strb.forceMin || takeMin) begin
        rspPort   <= minPort;
        rspNonMin <= 1'b0;
        rspMidGrp <= '0;
      end else begin
        rspPort   <= nonPort;
        rspNonMin <= 1'b1;
        rspMidGrp <= midGrp;
      end
    end
  end

endmodule

// File: rtl/ugal_path_chooser.sv
module ugal_path_chooser
  import ugal_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int OCC_W      = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  input  logic [$clog2(NUM_GROUPS)-1:0]         reqHereGrp,
  input  logic [$clog2(NUM_GROUPS)-1:0]         reqDstGrp,
  input  logic                                  reqNonMin,
  input  logic [(NUM_GROUPS-1)*OCC_W-1:0]       occFlat,
  input  logic [OCC_W-1:0]                      biasThr,
  output logic                                  rspValid,
  output logic [$clog2(NUM_GROUPS)-1:0]         rspPort,
  output logic                                  rspNonMin,
  output logic [$clog2(NUM_GROUPS)-1:0]         rspMidGrp
);

  ctrlStrb_t         strb;
  logic [RAND_W-1:0] randVal;

  ugal_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqHereGrp (reqHereGrp),
    .reqDstGrp  (reqDstGrp),
    .reqNonMin  (reqNonMin),
    .strb       (strb),
    .randVal    (randVal),
    .rspValid   (rspValid)
  );

  ugal_datapath #(.NUM_GROUPS(NUM_GROUPS), .OCC_W(OCC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .randVal   (randVal),
    .hereGrp   (reqHereGrp),
    .dstGrp    (reqDstGrp),
    .occFlat   (occFlat),
    .biasThr   (biasThr),
    .rspPort   (rspPort),
    .rspNonMin (rspNonMin),
    .rspMidGrp (rspMidGrp)
  );

endmodule

// File: rtl/ugal_path_chooser_chk.sv
module ugal_path_chooser_chk #(
  parameter int NUM_GROUPS = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          reqValid,
  input logic [$clog2(NUM_GROUPS)-1:0] reqHereGrp,
  input logic [$clog2(NUM_GROUPS)-1:0] reqDstGrp,
  input logic                          reqNonMin,
  input logic                          rspValid,
  input logic [$clog2(NUM_GROUPS)-1:0] rspPort,
  input logic                          rspNonMin,
  input logic [$clog2(NUM_GROUPS)-1:0] rspMidGrp
);

  localparam int GW = $clog2(NUM_GROUPS);
  localparam logic [GW-1:0] LOCAL_CODE = GW'(NUM_GROUPS - 1);

  // R1: response follows an accepted request by one cycle
  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R3: local-group destination gets the intra-group code
  a_r3_local_code: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqHereGrp == reqDstGrp) |=> (rspPort == LOCAL_CODE && !rspNonMin));

  // R4: second-hop packets are never detoured again
  a_r4_second_hop_min: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqNonMin) |=> !rspNonMin);

  // R2: a remote destination never gets the intra-group code
  a_r2_remote_global_port: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqHereGrp != reqDstGrp) |=> rspPort != LOCAL_CODE);

  // R7: the intermediate group avoids both endpoints
  a_r7_mid_distinct: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspNonMin) |-> (rspMidGrp != $past(reqHereGrp) &&
                                 rspMidGrp != $past(reqDstGrp)));

  // R9: minimal decisions report no intermediate group
  a_r9_mid_zero_when_min: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspNonMin) |-> rspMidGrp == '0);

endmodule

bind ugal_path_chooser ugal_path_chooser_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqHereGrp (reqHereGrp),
  .reqDstGrp  (reqDstGrp),
  .reqNonMin  (reqNonMin),
  .rspValid   (rspValid),
  .rspPort    (rspPort),
  .rspNonMin  (rspNonMin),
  .rspMidGrp  (rspMidGrp)
);

// File: tb/ugal_path_chooser_bench.sv
`timescale 1ns/1ps
module ugal_path_chooser_bench;

  localparam int G     = 8;
  localparam int GW    = 3;
  localparam int OW    = 8;
  localparam int NPORT = G - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [GW-1:0]     reqHereGrp = '0;
  logic [GW-1:0]     reqDstGrp = '0;
  logic              reqNonMin = 1'b0;
  logic [NPORT*OW-1:0] occFlat = '0;
  logic [OW-1:0]     biasThr = 8'd2;
  logic              rspValid;
  logic [GW-1:0]     rspPort;
  logic              rspNonMin;
  logic [GW-1:0]     rspMidGrp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] mdl;

  always #2 clk = ~clk;  // 250 MHz

  ugal_path_chooser #(.NUM_GROUPS(G), .OCC_W(OW)) u_ugal_path_chooser (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHereGrp(reqHereGrp),
    .reqDstGrp(reqDstGrp), .reqNonMin(reqNonMin), .occFlat(occFlat),
    .biasThr(biasThr), .rspValid(rspValid), .rspPort(rspPort),
    .rspNonMin(rspNonMin), .rspMidGrp(rspMidGrp)
  );

  function automatic logic [15:0] mStep(input logic [15:0] c);
    logic [15:0] n;
    n = c >> 1;
    if (c[0]) n = n ^ 16'hB400;
    return n;
  endfunction

  function automatic int portOf(input int h, input int g);
    return (g < h) ? g : g - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setOcc(input int p, input int v);
    occFlat[p*OW +: OW] = OW'(v);
  endtask

  task automatic clrOcc();
    occFlat = '0;
  endtask

  // issue one request, model it, sample one cycle later
  task automatic issue(input int h, input int d, input bit nm, input string req);
    int expPort, expMid, expNm, r, occMin, occNon, s;
    bit takeMin;
    @(negedge clk);
    reqValid = 1'b1; reqHereGrp = GW'(h); reqDstGrp = GW'(d); reqNonMin = nm;
    r = int'(mdl % 16'(G));
    if (r == h || r == d) r = (r + 1) % G;
    if (r == h || r == d) r = (r + 1) % G;
    if (h == d) begin
      expPort = G - 1; expNm = 0; expMid = 0;
    end else begin
      occMin = int'(occFlat[portOf(h, d)*OW +: OW]);
      occNon = int'(occFlat[portOf(h, r)*OW +: OW]);
      s = int'(biasThr) + occNon;
      if (s > 255) s = 255;
      takeMin = nm || (occMin < s);
      if (takeMin) begin
        expPort = portOf(h, d); expNm = 0; expMid = 0;
      end else begin
        expPort = portOf(h, r); expNm = 1; expMid = r;
      end
    end
    mdl = mStep(mdl);
    @(negedge clk);
    reqValid = 1'b0;
    chk({req, " rspValid"}, int'(rspValid), 1);
    chk({req, " port"}, int'(rspPort), expPort);
    chk({req, " nonMin"}, int'(rspNonMin), expNm);
    chk({req, " midGrp"}, int'(rspMidGrp), expMid);
  endtask

  task automatic t_reset();
    chk("R1 reset rspValid", int'(rspValid), 0);
    chk("R1 reset port", int'(rspPort), 0);
    chk("R1 reset nonMin", int'(rspNonMin), 0);
    chk("R1 reset mid", int'(rspMidGrp), 0);
  endtask

  task automatic t_local();
    clrOcc();
    for (int p = 0; p < NPORT; p++) setOcc(p, 250);
    issue(3, 3, 1'b0, "R3 local");
    issue(0, 0, 1'b1, "R3 local flagged");
  endtask

  task automatic t_ports();
    clrOcc(); biasThr = 8'd2;
    issue(4, 1, 1'b0, "R2 dst below here");
    issue(4, 6, 1'b0, "R2 dst above here");
    issue(0, 7, 1'b0, "R2 top group");
    issue(7, 0, 1'b0, "R2 bottom group");
  endtask

  task automatic t_compare();
    biasThr = 8'd2;
    for (int v = 4; v <= 6; v++) begin
      clrOcc();
      setOcc(portOf(5, 2), v);
      for (int p = 0; p < NPORT; p++) if (p != portOf(5, 2)) setOcc(p, 3);
      issue(5, 2, 1'b0, "R5 bias compare");
    end
    biasThr = 8'd0;
    for (int p = 0; p < NPORT; p++) setOcc(p, 3);
    issue(5, 2, 1'b0, "R5 tie zero bias");
    biasThr = 8'd2;
  endtask

  task automatic t_saturate();
    biasThr = 8'd200;
    for (int p = 0; p < NPORT; p++) setOcc(p, 100);
    setOcc(portOf(2, 6), 250);
    issue(2, 6, 1'b0, "R6 saturating sum");
    chk("R6 minimal kept", int'(rspNonMin), 0);
    setOcc(portOf(2, 6), 255);
    issue(2, 6, 1'b0, "R6 saturated tie");
    chk("R6 tie detours", int'(rspNonMin), 1);
    biasThr = 8'd2;
  endtask

  task automatic t_second_hop();
    clrOcc(); biasThr = 8'd1;
    setOcc(portOf(3, 6), 255);
    issue(3, 6, 1'b1, "R4 second hop");
    chk("R4 no detour", int'(rspNonMin), 0);
    issue(3, 6, 1'b0, "R9 fresh packet detours");
    chk("R9 detour flagged", int'(rspNonMin), 1);
    biasThr = 8'd2;
  endtask

  task automatic t_draws();
    biasThr = 8'd1;
    for (int i = 0; i < 48; i++) begin
      int h, d;
      h = i % G; d = (h + 1) % G;
      clrOcc();
      setOcc(portOf(h, d), 255);
      issue(h, d, 1'b0, "R7 R8 draw");
      chk("R7 mid not here", int'(rspMidGrp == GW'(h)), 0);
      chk("R7 mid not dst", int'(rspMidGrp == GW'(d)), 0);
    end
    biasThr = 8'd2;
  endtask

  task automatic t_idle_gap();
    biasThr = 8'd1; clrOcc();
    setOcc(portOf(6, 1), 255);
    repeat (5) @(negedge clk);
    issue(6, 1, 1'b0, "R8 after idle gap");
    repeat (3) @(negedge clk);
    issue(6, 1, 1'b0, "R8 after second gap");
    biasThr = 8'd2;
  endtask

  task automatic t_latency();
    @(negedge clk);
    chk("R1 rspValid drops when idle", int'(rspValid), 0);
  endtask

  initial begin
    mdl = 16'hACE1;
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_local();
    t_ports();
    t_compare();
    t_saturate();
    t_second_hop();
    t_draws();
    t_idle_gap();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule